// File: doc/BRIEF.md
# Decoded Micro-Op Line Cache Controller

This block keeps recently decoded micro-ops so the front end can skip the legacy decode path for code it has already decoded. Each line stands for one aligned 32-byte window of virtual code space. A line holds up to six fixed-width micro-op words. The cache is set-associative, and its tags hold virtual addresses, so no translation is needed before the compare. The legacy decoder fills lines as a side effect of its normal work. A line is committed only when the decoder marks the end of the window. A window that decodes into more than six micro-ops is recorded as uncacheable.

The cache is consulted only when the branch unit redirects fetch. On a hit, the block switches its source select to the cache. It then streams one line per cycle, walking consecutive windows, until a window misses. After that miss, delivery falls back to the legacy path and no tags are read until the next redirect. An eviction in the instruction TLB clears every line, so the cache never holds code whose translation has gone. Replacement within a set prefers an empty way, then a tree pseudo-LRU victim.

Top module: `uopc_ctrl`

## Requirements
- R1: After reset, `src_uc` is 0 and `uop_vld` is all zeros. Whenever `src_uc` is 0, `uop_vld` is all zeros.
- R2: A redirect whose window is held as a cacheable line gives, on the next clock edge, `src_uc`=1, `uop_vld` with its lowest N bits set (N = micro-ops in the line), and micro-op k in `uop_out[k*UOP_W +: UOP_W]` in fill order.
- R3: A redirect that misses gives `src_uc`=0 and `uop_vld`=0 on the next edge. In legacy mode with no redirect, `src_uc` stays 0, even if the missed window is filled meanwhile.
- R4: While `src_uc` is 1, each following cycle looks up the next consecutive 32-byte window, with no redirect needed. The first miss returns to legacy mode.
- R5: The set is fetch address bits [5 +: log2(SETS)] and the tag is the bits above them. Bits [4:0] do not affect the lookup. Windows that share a set but differ in tag never hit each other.
- R6: A window filled with more than six micro-ops always misses. A later fill of the same window with six or fewer replaces it in the same way and then hits.
- R7: A line becomes visible only after the fill beat carrying `fill_end`. A redirect to a window whose fill is still open misses.
- R8: `tlb_evict` empties the cache and forces `src_uc` to 0 on the next edge. A fill that is open, or started in the evict cycle, is discarded up to and including its end beat.
- R9: A fill goes to the way already holding its window; otherwise the lowest empty way; otherwise the tree pseudo-LRU victim, which is updated on every hit and fill. After fills to ways 0..7 in order and then a hit on way 0, the victim is way 4.
- R10: A window of exactly six micro-ops is cacheable, and all six slots are delivered valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| redirect | input | 1 | Branch redirect strobe; `fetch_va` holds the target |
| fetch_va | input | VA_W | Virtual fetch target address |
| tlb_evict | input | 1 | Instruction TLB eviction strobe; flushes the cache |
| fill_vld | input | 1 | One decoded micro-op from the legacy decoder |
| fill_va | input | VA_W | Virtual address of the window being decoded |
| fill_uop | input | UOP_W | Decoded micro-op word |
| fill_end | input | 1 | This beat is the last of its window |
| uop_out | output | SLOTS*UOP_W | Delivered micro-ops, slot k at bits k*UOP_W |
| uop_vld | output | SLOTS | Valid bit per delivered slot |
| src_uc | output | 1 | 1: delivery from this cache; 0: legacy decode path |

## Verification
The hardest state to reach is a full set whose pseudo-LRU victim differs from the true least-recent way. The stimulus fills eight windows that share one set index, in order. It then redirects to the first of them, and the streamed neighbour window misses at once, so this is the only hit. A ninth fill follows. Probing shows that way 4, not way 1, was replaced. A second hard case is a TLB eviction landing mid-fill. The bench drives it by asserting the eviction on an interior decode beat and then completing the window.

// File: rtl/uopc_pkg.sv
package uopc_pkg;

    typedef enum logic {
        SRC_LEGACY = 1'b0,
        SRC_UCACHE = 1'b1
    } src_e;

endpackage

// File: rtl/uopc_fill.sv
module uopc_fill #(
    parameter int VA_W  = 32,
    parameter int UOP_W = 16,
    parameter int SLOTS = 6,
    parameter int OFS_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           fill_vld,
    input  logic [VA_W-1:0]                fill_va,
    input  logic [UOP_W-1:0]               fill_uop,
    input  logic                           fill_end,
    output logic                           wr_en,
    output logic [VA_W-OFS_W-1:0]          wr_region,
    output logic [SLOTS*UOP_W-1:0]         wr_uops,
    output logic [$clog2(SLOTS+1)-1:0]     wr_cnt,
    output logic                           wr_nc
);
    localparam int RG_W  = VA_W - OFS_W;
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic                            busy;
        logic                            drop;
        logic                            ovf;
        logic [RG_W-1:0]                 rg;
        logic [CNT_W-1:0]                cnt;
        logic [SLOTS-1:0][UOP_W-1:0]     uops;
    } fb_s;

    fb_s q, d;

    logic [CNT_W-1:0]             cur_cnt, m_cnt;
    logic                         m_ovf;
    logic [RG_W-1:0]              cur_rg;
    logic [SLOTS-1:0][UOP_W-1:0]  m_uops;
    logic                         unused_fill_ofs;

    assign unused_fill_ofs = ^fill_va[OFS_W-1:0];

    always_comb begin
        cur_cnt = q.busy ? q.cnt : '0;
        cur_rg  = q.busy ? q.rg : fill_va[VA_W-1:OFS_W];
        m_uops  = q.busy ? q.uops : '0;
        m_cnt   = cur_cnt;
        m_ovf   = q.busy & q.ovf;
        if (fill_vld) begin
            if (cur_cnt < CNT_W'(SLOTS)) begin
                m_uops[cur_cnt] = fill_uop;
                m_cnt           = cur_cnt + CNT_W'(1);
            end else begin
                m_ovf = 1'b1;
            end
        end

        wr_en     = 1'b0;
        wr_region = cur_rg;
        wr_uops   = m_uops;
        wr_cnt    = m_cnt;
        wr_nc     = m_ovf;

        d = q;
        if (flush) begin
            d.busy = 1'b0;
            d.drop = (q.busy | q.drop | fill_vld) & ~(fill_vld & fill_end);
            d.cnt  = '0;
            d.ovf  = 1'b0;
        end else if (q.drop) begin
            if (fill_vld && fill_end) d.drop = 1'b0;
        end else if (fill_vld) begin
            if (fill_end) begin
                wr_en  = 1'b1;
                d.busy = 1'b0;
                d.cnt  = '0;
                d.ovf  = 1'b0;
            end else begin
                d.busy = 1'b1;
                d.rg   = cur_rg;
                d.cnt  = m_cnt;
                d.ovf  = m_ovf;
                d.uops = m_uops;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a window interrupted by a flush must not commit its tail
    a_r8_fill_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && fill_vld && !fill_end) |=> !wr_en);

endmodule

// File: rtl/uopc_plru.sv
module uopc_plru #(
    parameter int SETS = 32,
    parameter int WAYS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      touch_en,
    input  logic [$clog2(SETS)-1:0]   touch_set,
    input  logic [$clog2(WAYS)-1:0]   touch_way,
    input  logic                      fill_en,
    input  logic [$clog2(SETS)-1:0]   fill_set,
    input  logic [$clog2(WAYS)-1:0]   fill_way,
    output logic [$clog2(WAYS)-1:0]   vict_way
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int NODES = WAYS - 1;

    typedef struct packed {
        logic [SETS-1:0][NODES-1:0] bits;
    } pl_s;

    pl_s q, d;

    function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] b);
        int n;
        n = 1;
        for (int l = 0; l < WAY_W; l++) begin
            n = 2 * n + (b[n-1] ? 1 : 0);
        end
        return WAY_W'(n - WAYS);
    endfunction

    function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] b,
                                               input logic [WAY_W-1:0] w);
        logic [NODES-1:0] r;
        int n;
        r = b;
        n = 1;
        for (int l = 0; l < WAY_W; l++) begin
            r[n-1] = ~w[WAY_W-1-l];
            n = 2 * n + (w[WAY_W-1-l] ? 1 : 0);
        end
        return r;
    endfunction

    always_comb begin
        d = q;
        if (flush) begin
            d.bits = '0;
        end else begin
            if (touch_en) d.bits[touch_set] = touch(d.bits[touch_set], touch_way);
            if (fill_en)  d.bits[fill_set]  = touch(d.bits[fill_set], fill_way);
        end
        vict_way = pick(q.bits[fill_set]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/uopc_store.sv
module uopc_store #(
    parameter int VA_W  = 32,
    parameter int UOP_W = 16,
    parameter int SETS  = 32,
    parameter int WAYS  = 8,
    parameter int SLOTS = 6,
    parameter int OFS_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [VA_W-OFS_W-1:0]          rd_region,
    output logic                           rd_hit,
    output logic [$clog2(WAYS)-1:0]        rd_way,
    output logic [SLOTS*UOP_W-1:0]         rd_uops,
    output logic [$clog2(SLOTS+1)-1:0]     rd_cnt,
    input  logic                           wr_en,
    input  logic [VA_W-OFS_W-1:0]          wr_region,
    input  logic [SLOTS*UOP_W-1:0]         wr_uops,
    input  logic [$clog2(SLOTS+1)-1:0]     wr_cnt,
    input  logic                           wr_nc,
    input  logic [$clog2(WAYS)-1:0]        vict_way,
    output logic [$clog2(WAYS)-1:0]        wr_way
);
    localparam int RG_W  = VA_W - OFS_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = RG_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0] vld;
        logic [SETS-1:0][WAYS-1:0] nc;
    } flg_s;

    flg_s q, d;

    logic [TAG_W-1:0]       tag_mem  [SETS][WAYS];
    logic [CNT_W-1:0]       cnt_mem  [SETS][WAYS];
    logic [SLOTS*UOP_W-1:0] data_mem [SETS][WAYS];

    logic [IDX_W-1:0] r_idx, w_idx;
    logic [TAG_W-1:0] r_tag, w_tag;
    logic [WAYS-1:0]  r_same, r_match, w_same, w_free;

    assign r_idx = rd_region[IDX_W-1:0];
    assign r_tag = rd_region[RG_W-1:IDX_W];
    assign w_idx = wr_region[IDX_W-1:0];
    assign w_tag = wr_region[RG_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            r_same[w]  = q.vld[r_idx][w] && (tag_mem[r_idx][w] == r_tag);
            r_match[w] = r_same[w] && !q.nc[r_idx][w];
            w_same[w]  = q.vld[w_idx][w] && (tag_mem[w_idx][w] == w_tag);
            w_free[w]  = !q.vld[w_idx][w];
        end
        rd_hit = |r_match;
        rd_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (r_match[w]) rd_way = WAY_W'(w);
        end
        rd_uops = data_mem[r_idx][rd_way];
        rd_cnt  = cnt_mem[r_idx][rd_way];

        wr_way = vict_way;
        if (|w_same) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (w_same[w]) wr_way = WAY_W'(w);
            end
        end else if (|w_free) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (w_free[w]) wr_way = WAY_W'(w);
            end
        end

        d = q;
        if (flush) begin
            d.vld = '0;
            d.nc  = '0;
        end else if (wr_en) begin
            d.vld[w_idx][wr_way] = 1'b1;
            d.nc[w_idx][wr_way]  = wr_nc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_mem[w_idx][wr_way]  <= w_tag;
            cnt_mem[w_idx][wr_way]  <= wr_cnt;
            data_mem[w_idx][wr_way] <= wr_uops;
        end
    end

    // R9: a window never occupies two ways of its set
    a_r9_one_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(r_same) <= 1);

    // R8: nothing survives a flush into the following cycle
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rd_hit);

endmodule

// File: rtl/uopc_ctrl.sv
module uopc_ctrl
    import uopc_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int UOP_W    = 16,
    parameter int SETS     = 32,
    parameter int WAYS     = 8,
    parameter int SLOTS    = 6,
    parameter int REGION_B = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     redirect,
    input  logic [VA_W-1:0]          fetch_va,
    input  logic                     tlb_evict,
    input  logic                     fill_vld,
    input  logic [VA_W-1:0]          fill_va,
    input  logic [UOP_W-1:0]         fill_uop,
    input  logic                     fill_end,
    output logic [SLOTS*UOP_W-1:0]   uop_out,
    output logic [SLOTS-1:0]         uop_vld,
    output logic                     src_uc
);
    localparam int OFS_W = $clog2(REGION_B);
    localparam int IDX_W = $clog2(SETS);
    localparam int RG_W  = VA_W - OFS_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        src_e                     mode;
        logic [RG_W-1:0]          next_rg;
        logic [SLOTS*UOP_W-1:0]   uops;
        logic [SLOTS-1:0]         vld;
    } ctl_s;

    ctl_s q, d;

    logic                   probe_en, hit;
    logic [RG_W-1:0]        probe_rg;
    logic                   rd_hit;
    logic [WAY_W-1:0]       rd_way, wr_way, vict_way;
    logic [SLOTS*UOP_W-1:0] rd_uops, wr_uops;
    logic [CNT_W-1:0]       rd_cnt, wr_cnt;
    logic                   wr_en, wr_nc;
    logic [RG_W-1:0]        wr_region;
    logic                   unused_fetch_ofs;

    assign unused_fetch_ofs = ^fetch_va[OFS_W-1:0];

    always_comb begin
        probe_en = redirect | (q.mode == SRC_UCACHE);
        probe_rg = redirect ? fetch_va[VA_W-1:OFS_W] : q.next_rg;
        hit      = probe_en & rd_hit & ~tlb_evict;
        d = q;
        if (hit) begin
            d.mode    = SRC_UCACHE;
            d.next_rg = probe_rg + RG_W'(1);
            d.uops    = rd_uops;
            for (int i = 0; i < SLOTS; i++) begin
                d.vld[i] = (CNT_W'(i) < rd_cnt);
            end
        end else begin
            d.mode = SRC_LEGACY;
            d.uops = '0;
            d.vld  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode    <= SRC_LEGACY;
            q.next_rg <= '0;
            q.uops    <= '0;
            q.vld     <= '0;
        end else begin
            q <= d;
        end
    end

    assign uop_out = q.uops;
    assign uop_vld = q.vld;
    assign src_uc  = (q.mode == SRC_UCACHE);

    uopc_fill #(
        .VA_W(VA_W), .UOP_W(UOP_W), .SLOTS(SLOTS), .OFS_W(OFS_W)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .flush(tlb_evict),
        .fill_vld(fill_vld), .fill_va(fill_va), .fill_uop(fill_uop), .fill_end(fill_end),
        .wr_en(wr_en), .wr_region(wr_region), .wr_uops(wr_uops),
        .wr_cnt(wr_cnt), .wr_nc(wr_nc)
    );

    uopc_store #(
        .VA_W(VA_W), .UOP_W(UOP_W), .SETS(SETS), .WAYS(WAYS), .SLOTS(SLOTS), .OFS_W(OFS_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(tlb_evict),
        .rd_region(probe_rg), .rd_hit(rd_hit), .rd_way(rd_way),
        .rd_uops(rd_uops), .rd_cnt(rd_cnt),
        .wr_en(wr_en), .wr_region(wr_region), .wr_uops(wr_uops),
        .wr_cnt(wr_cnt), .wr_nc(wr_nc), .vict_way(vict_way), .wr_way(wr_way)
    );

    uopc_plru #(
        .SETS(SETS), .WAYS(WAYS)
    ) u_plru (
        .clk(clk), .rst_n(rst_n), .flush(tlb_evict),
        .touch_en(hit), .touch_set(probe_rg[IDX_W-1:0]), .touch_way(rd_way),
        .fill_en(wr_en), .fill_set(wr_region[IDX_W-1:0]), .fill_way(wr_way),
        .vict_way(vict_way)
    );

    // R1: legacy delivery carries no cached slots
    a_r1_legacy_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !src_uc |-> (uop_vld == '0));

    // R2: cached delivery has a non-empty run of valid slots from slot 0
    a_r2_vld_shape: assert property (@(posedge clk) disable iff (!rst_n)
        src_uc |-> ((uop_vld != '0) && ((uop_vld & (uop_vld + SLOTS'(1))) == '0)));

    // R3: without a redirect, legacy mode never switches to the cache
    a_r3_legacy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_uc && !redirect) |=> !src_uc);

    // R8: an eviction forces the legacy path on the next edge
    a_r8_evict_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_evict |=> !src_uc);

endmodule

// File: tb/sim_uopc_ctrl.sv
module sim_uopc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, redirect, tlb_evict, fill_vld, fill_end;
    logic [31:0] fetch_va, fill_va;
    logic [15:0] fill_uop;
    logic [95:0] uop_out;
    logic [5:0]  uop_vld;
    logic        src_uc;
    int          total = 0;
    int          bad   = 0;

    always #10 clk = ~clk;

    uopc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .fetch_va(fetch_va),
        .tlb_evict(tlb_evict), .fill_vld(fill_vld), .fill_va(fill_va),
        .fill_uop(fill_uop), .fill_end(fill_end),
        .uop_out(uop_out), .uop_vld(uop_vld), .src_uc(src_uc)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] uv(logic [31:0] va, int i);
        logic [31:0] t;
        t = (va >> 5) * 8 + 32'(i) + 1;
        return t[15:0];
    endfunction

    function automatic logic [31:0] rva(int tag, int idx);
        return 32'(tag * 1024 + idx * 32);
    endfunction

    task automatic expect_line(string tag, logic [31:0] va, int n);
        chk({tag, " src"}, 32'(src_uc), 32'd1);
        chk({tag, " vld"}, 32'(uop_vld), (32'd1 << n) - 1);
        for (int i = 0; i < n; i++) begin
            chk({tag, " uop"}, 32'(uop_out[i*16 +: 16]), 32'(uv(va, i)));
        end
    endtask

    task automatic expect_miss(string tag);
        chk({tag, " src"}, 32'(src_uc), 32'd0);
        chk({tag, " vld"}, 32'(uop_vld), 32'd0);
    endtask

    task automatic fill(logic [31:0] va, int n);
        for (int i = 0; i < n; i++) begin
            fill_vld = 1'b1;
            fill_va  = va;
            fill_uop = uv(va, i);
            fill_end = (i == n - 1);
            tick();
        end
        fill_vld = 1'b0;
        fill_end = 1'b0;
    endtask

    task automatic probe(logic [31:0] va);
        fetch_va = va;
        redirect = 1'b1;
        tick();
        redirect = 1'b0;
    endtask

    task automatic t_reset();
        expect_miss("R1 reset");
    endtask

    task automatic t_hit_basic();
        logic [31:0] a;
        a = rva(1, 3);
        fill(a, 4);
        tick();
        expect_miss("R3 no probe without redirect");
        probe(a + 32'd13);
        expect_line("R2 R5 hit with offset", a, 4);
        tick();
        expect_miss("R4 stream ends at empty neighbour");
    endtask

    task automatic t_miss_hold();
        logic [31:0] b;
        b = rva(2, 5);
        probe(b);
        expect_miss("R3 redirect miss");
        fill(b, 3);
        tick();
        tick();
        expect_miss("R3 stays legacy after fill");
        probe(b);
        expect_line("R3 hit after new redirect", b, 3);
    endtask

    task automatic t_stream();
        fill(rva(3, 10), 2);
        fill(rva(3, 11), 5);
        fill(rva(3, 12), 6);
        probe(rva(3, 10));
        expect_line("R4 stream line 0", rva(3, 10), 2);
        tick();
        expect_line("R4 stream line 1", rva(3, 11), 5);
        tick();
        expect_line("R10 stream six-uop line", rva(3, 12), 6);
        tick();
        expect_miss("R4 stream stop");
    endtask

    task automatic t_overflow();
        logic [31:0] dv;
        dv = rva(4, 15);
        fill(dv, 7);
        probe(dv);
        expect_miss("R6 seven uops uncacheable");
        fill(dv, 3);
        probe(dv);
        expect_line("R6 refill replaces", dv, 3);
    endtask

    task automatic t_partial();
        logic [31:0] e;
        e = rva(5, 17);
        for (int i = 0; i < 3; i++) begin
            fill_vld = 1'b1;
            fill_va  = e;
            fill_uop = uv(e, i);
            fill_end = 1'b0;
            tick();
        end
        fill_vld = 1'b0;
        probe(e);
        expect_miss("R7 open fill invisible");
        fill_vld = 1'b1;
        fill_va  = e;
        fill_uop = uv(e, 3);
        fill_end = 1'b1;
        tick();
        fill_vld = 1'b0;
        fill_end = 1'b0;
        probe(e);
        expect_line("R7 committed at end", e, 4);
    endtask

    task automatic t_alias();
        probe(rva(6, 3));
        expect_miss("R5 same set other tag");
        probe(rva(1, 3));
        expect_line("R5 original still held", rva(1, 3), 4);
    endtask

    task automatic t_flush();
        logic [31:0] g;
        probe(rva(3, 10));
        expect_line("R8 pre-evict hit", rva(3, 10), 2);
        tlb_evict = 1'b1;
        tick();
        tlb_evict = 1'b0;
        expect_miss("R8 evict forces legacy");
        probe(rva(3, 11));
        expect_miss("R8 stream line gone");
        probe(rva(1, 3));
        expect_miss("R8 line gone");
        g = rva(7, 25);
        for (int i = 0; i < 4; i++) begin
            fill_vld  = 1'b1;
            fill_va   = g;
            fill_uop  = uv(g, i);
            fill_end  = (i == 3);
            tlb_evict = (i == 1);
            tick();
        end
        fill_vld  = 1'b0;
        fill_end  = 1'b0;
        tlb_evict = 1'b0;
        probe(g);
        expect_miss("R8 interrupted fill dropped");
        fill(g, 2);
        probe(g);
        expect_line("R8 fill after drop", g, 2);
    endtask

    task automatic t_plru();
        for (int t = 1; t <= 8; t++) fill(rva(t, 20), 1);
        probe(rva(1, 20));
        expect_line("R9 touch way 0", rva(1, 20), 1);
        tick();
        fill(rva(9, 20), 1);
        probe(rva(5, 20));
        expect_miss("R9 way 4 victim");
        probe(rva(1, 20));
        expect_line("R9 way 0 kept", rva(1, 20), 1);
        probe(rva(2, 20));
        expect_line("R9 way 1 kept", rva(2, 20), 1);
        probe(rva(9, 20));
        expect_line("R9 new line", rva(9, 20), 1);
        probe(rva(6, 20));
        expect_line("R9 way 5 kept", rva(6, 20), 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; redirect = 1'b0; tlb_evict = 1'b0;
        fill_vld = 1'b0; fill_end = 1'b0;
        fetch_va = '0; fill_va = '0; fill_uop = '0;
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_hit_basic();
        t_miss_hold();
        t_stream();
        t_overflow();
        t_partial();
        t_alias();
        t_flush();
        t_plru();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule